// File: doc/BRIEF.md
# Flash Command Sequencer with Embedded-Operation Status

This block sits between a byte-wide host bus and a flash array model. It watches host writes for unlock chains on two fixed addresses. A complete chain either starts an embedded byte program or sector erase, or switches the read path into identification mode. An embedded operation is a cycle counter whose lengths are parameters. While it runs, every host read returns a status byte instead of array data. When the counter expires, the block writes the byte, or pulses a whole-sector erase, through a simple port to the array outside the block.

In identification mode, reads at three fixed addresses return the maker code, the part code and the state of the two protection pins. All other reads return array data. Writes to a protected sector, and attempts to set a bit from 0 to 1, never change the array.

Top module: `flash_cmd_seq`

## Requirements
- R1: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, then data D at address A (low 15 address bits compared for the unlock steps) start a program. `busy` is high for exactly PROG_CYCLES cycles starting the cycle after the final write, and D is then stored at A.
- R2: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address start an erase. The erase covers the sector chosen by address bits [18:16]. `busy` is high for ERASE_CYCLES cycles, after which every byte of that sector reads FFh.
- R3: A read while busy returns status rather than array data. Bit 7 is the inverse of bit 7 of the programmed byte during a program and 0 during an erase, and bits 4..0 are 0.
- R4: Status bit 6 is 0 on the first read after an operation starts and inverts on every further read while busy.
- R5: A program whose data has a 1 where the stored byte has a 0 writes nothing and sets status bit 5. `busy` then stays high and all writes are ignored until reset.
- R6: The top sector (index 7) is protected while `boot_lock_n` is low, and every other sector while `wprot_n` is low. A program or erase aimed at a protected sector holds `busy` for PROT_CYCLES cycles and leaves the array unchanged.
- R7: AAh@5555h, 55h@2AAAh, 90h@5555h enter identification mode. In that mode, address 0 reads DAh and address 1 reads 54h. Address 7FFF2h reads `~boot_lock_n` on bit 2 and `~wprot_n` on bit 3, with the other bits 0.
- R8: Identification mode ends on the chain AAh@5555h, 55h@2AAAh, F0h@5555h, or on a single F0h write to any address. Reads then return array data again.
- R9: A write that does not match the next expected step of a chain returns the decoder to idle, and no operation starts.
- R10: After reset, `busy` is 0, `rdata` is 0 and identification mode is off.
- R11: A read while idle returns the array byte at the read address. `rdata` updates one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Host byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data or status |
| busy | output | 1 | High during an embedded operation |
| boot_lock_n | input | 1 | Low protects the top sector |
| wprot_n | input | 1 | Low protects all other sectors |
| arr_addr | output | ADDR_W | Array address (host address when idle, operation address when busy) |
| arr_wdata | output | 8 | Byte to store in the array |
| arr_we | output | 1 | One-cycle array byte write |
| arr_erase | output | 1 | One-cycle erase of the sector in arr_addr[18:16] |
| arr_rdata | input | 8 | Array byte at arr_addr, combinational |

## Verification
`rdata` is due one cycle after the `rd_en` cycle, so the bench drives each read at a falling edge and samples at the next falling edge. `busy` rises at the edge that takes the final write of a chain. The bench starts counting falling edges right after that edge and requires exactly PROG_CYCLES, ERASE_CYCLES or PROT_CYCLES of them with `busy` high. Array contents are only checked once `busy` has dropped, because the commit happens on the last busy edge. Status values are checked exactly from the first read after the start, since the toggle bit begins at 0.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    OP_IDLE, OP_PROG, OP_ERASE, OP_GUARD, OP_STUCK
  } op_kind_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PGM, SQ_ERA1, SQ_ERA2, SQ_ERA3
  } seq_st_t;

  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;
  localparam logic [7:0]  KEY_AA   = 8'hAA;
  localparam logic [7:0]  KEY_55   = 8'h55;
  localparam logic [7:0]  CMD_PGM  = 8'hA0;
  localparam logic [7:0]  CMD_ERS  = 8'h80;
  localparam logic [7:0]  CMD_SEC  = 8'h30;
  localparam logic [7:0]  CMD_IDIN = 8'h90;
  localparam logic [7:0]  CMD_IDOUT = 8'hF0;
endpackage

// File: rtl/fcs_cmd_decoder.sv
module fcs_cmd_decoder
  import flash_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        busy,
  input  logic [14:0] addr_lo,
  input  logic [7:0]  wdata,
  output logic        start_prog,
  output logic        start_erase,
  output logic        id_mode
);
  seq_st_t st_q, st_d;
  logic    id_q, id_d;

  always_comb begin
    st_d        = st_q;
    id_d        = id_q;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    if (wr_en && !busy) begin
      st_d = SQ_IDLE;
      case (st_q)
        SQ_IDLE: begin
          if (addr_lo == UNLOCK_A && wdata == KEY_AA) st_d = SQ_UNL1;
          else if (wdata == CMD_IDOUT)                 id_d = 1'b0;
        end
        SQ_UNL1: if (addr_lo == UNLOCK_B && wdata == KEY_55) st_d = SQ_UNL2;
        SQ_UNL2: begin
          if (addr_lo == UNLOCK_A) begin
            case (wdata)
              CMD_PGM:   st_d = SQ_PGM;
              CMD_ERS:   st_d = SQ_ERA1;
              CMD_IDIN:  id_d = 1'b1;
              CMD_IDOUT: id_d = 1'b0;
              default:   st_d = SQ_IDLE;
            endcase
          end
        end
        SQ_PGM:  start_prog = 1'b1;
        SQ_ERA1: if (addr_lo == UNLOCK_A && wdata == KEY_AA) st_d = SQ_ERA2;
        SQ_ERA2: if (addr_lo == UNLOCK_B && wdata == KEY_55) st_d = SQ_ERA3;
        SQ_ERA3: if (wdata == CMD_SEC) start_erase = 1'b1;
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
      id_q <= 1'b0;
    end else begin
      st_q <= st_d;
      id_q <= id_d;
    end
  end

  assign id_mode = id_q;

  assert_one_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_prog && start_erase));

  assert_single_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && st_q == SQ_IDLE && wdata == CMD_IDOUT) |=> !id_mode);
endmodule

// File: rtl/fcs_op_engine.sv
module fcs_op_engine
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int PROG_CYCLES  = 12,
  parameter int ERASE_CYCLES = 40,
  parameter int PROT_CYCLES  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              req_prot,
  input  logic              req_bad,
  input  logic              rd_en,
  output logic              busy,
  output logic [7:0]        status,
  output logic              arr_we,
  output logic              arr_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);
  localparam int MAX_A  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int MAX_C  = (MAX_A > PROT_CYCLES) ? MAX_A : PROT_CYCLES;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  op_kind_t          kind_q, kind_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic              isp_q, isp_d;
  logic              tog_q, tog_d;
  logic              timed;

  assign timed = (kind_q == OP_PROG) || (kind_q == OP_ERASE) || (kind_q == OP_GUARD);

  always_comb begin
    kind_d = kind_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    data_d = data_q;
    isp_d  = isp_q;
    tog_d  = tog_q;
    if (start_prog || start_erase) begin
      addr_d = req_addr;
      data_d = req_data;
      isp_d  = start_prog;
      tog_d  = 1'b0;
      if (req_prot) begin
        kind_d = OP_GUARD;
        cnt_d  = CNT_W'(PROT_CYCLES - 1);
      end else if (start_erase) begin
        kind_d = OP_ERASE;
        cnt_d  = CNT_W'(ERASE_CYCLES - 1);
      end else if (req_bad) begin
        kind_d = OP_STUCK;
      end else begin
        kind_d = OP_PROG;
        cnt_d  = CNT_W'(PROG_CYCLES - 1);
      end
    end else if (timed) begin
      if (cnt_q == '0) kind_d = OP_IDLE;
      else             cnt_d  = cnt_q - 1'b1;
    end
    if (rd_en && busy) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OP_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      isp_q  <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      data_q <= data_d;
      isp_q  <= isp_d;
      tog_q  <= tog_d;
    end
  end

  assign busy      = (kind_q != OP_IDLE);
  assign arr_we    = (kind_q == OP_PROG)  && (cnt_q == '0);
  assign arr_erase = (kind_q == OP_ERASE) && (cnt_q == '0);
  assign op_addr   = addr_q;
  assign op_data   = data_q;
  assign status    = {isp_q & ~data_q[7], tog_q, kind_q == OP_STUCK, 5'b0};

  assert_start_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_erase) |-> !busy);

  assert_commit_then_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we || arr_erase) |=> !busy);

  assert_stuck_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == OP_STUCK) |=> (busy && !arr_we && !arr_erase && status[5]));

  assert_guard_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == OP_GUARD) |=> !(arr_we || arr_erase));
endmodule

// File: rtl/fcs_read_mux.sv
module fcs_read_mux #(
  parameter int          ADDR_W      = 19,
  parameter logic [7:0]  MFR_CODE    = 8'hDA,
  parameter logic [7:0]  PART_CODE   = 8'h54,
  parameter logic [31:0] PINS_ADDR   = 32'h7FFF2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              id_mode,
  input  logic              busy,
  input  logic [7:0]        status,
  input  logic [7:0]        arr_rdata,
  input  logic              boot_lock_n,
  input  logic              wprot_n,
  output logic [7:0]        rdata
);
  localparam logic [ADDR_W-1:0] A_PINS = PINS_ADDR[ADDR_W-1:0];

  logic [7:0] rd_q, rd_d;

  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      if (busy)                                   rd_d = status;
      else if (id_mode && addr == ADDR_W'(0))     rd_d = MFR_CODE;
      else if (id_mode && addr == ADDR_W'(1))     rd_d = PART_CODE;
      else if (id_mode && addr == A_PINS)         rd_d = {4'b0, ~wprot_n, ~boot_lock_n, 2'b0};
      else                                        rd_d = arr_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 8'h00;
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;

  assert_status_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rdata[4:0] == 5'b0));

  assert_id_maker_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy && id_mode && addr == ADDR_W'(0)) |=> (rdata == MFR_CODE));

  assert_hold_no_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int SECT_W       = 3,
  parameter int PROG_CYCLES  = 12,
  parameter int ERASE_CYCLES = 40,
  parameter int PROT_CYCLES  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              busy,
  input  logic              boot_lock_n,
  input  logic              wprot_n,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              arr_we,
  output logic              arr_erase,
  input  logic [7:0]        arr_rdata
);
  localparam logic [SECT_W-1:0] TOP_SECT = '1;

  logic [1:0]        rst_sync;
  logic              rst_i;
  logic              start_prog, start_erase, id_mode;
  logic              req_prot, req_bad;
  logic [SECT_W-1:0] sect;
  logic [7:0]        status;
  logic [ADDR_W-1:0] op_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign sect     = addr[ADDR_W-1 -: SECT_W];
  assign req_prot = (sect == TOP_SECT) ? !boot_lock_n : !wprot_n;
  assign req_bad  = |(wdata & ~arr_rdata);
  assign arr_addr = busy ? op_addr : addr;

  fcs_cmd_decoder u_dec (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .busy(busy),
    .addr_lo(addr[14:0]), .wdata(wdata),
    .start_prog(start_prog), .start_erase(start_erase), .id_mode(id_mode)
  );

  fcs_op_engine #(
    .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES), .PROT_CYCLES(PROT_CYCLES)
  ) u_eng (
    .clk(clk), .rst_n(rst_i), .start_prog(start_prog), .start_erase(start_erase),
    .req_addr(addr), .req_data(wdata), .req_prot(req_prot), .req_bad(req_bad),
    .rd_en(rd_en), .busy(busy), .status(status), .arr_we(arr_we),
    .arr_erase(arr_erase), .op_addr(op_addr), .op_data(arr_wdata)
  );

  fcs_read_mux #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_i), .rd_en(rd_en), .addr(addr), .id_mode(id_mode),
    .busy(busy), .status(status), .arr_rdata(arr_rdata),
    .boot_lock_n(boot_lock_n), .wprot_n(wprot_n), .rdata(rdata)
  );

  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(rst_i) |-> (!busy && rdata == 8'h00));
endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int PROG_C = 12, ERASE_C = 40, PROT_C = 6;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en, boot_lock_n, wprot_n;
  logic [18:0] addr, arr_addr;
  logic [7:0]  wdata, rdata, arr_wdata, arr_rdata;
  logic        busy, arr_we, arr_erase, fill_en;
  int          total = 0, fails = 0;
  logic [7:0]  mem [0:255];
  logic [7:0]  expm [0:255];

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.PROG_CYCLES(PROG_C), .ERASE_CYCLES(ERASE_C), .PROT_CYCLES(PROT_C)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .boot_lock_n(boot_lock_n), .wprot_n(wprot_n),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_we(arr_we), .arr_erase(arr_erase),
    .arr_rdata(arr_rdata)
  );

  function automatic logic [7:0] ix(input logic [18:0] a);
    return {a[18:16], a[4:0]};
  endfunction
  function automatic logic [7:0] pat(input int k);
    return 8'((k * 29 + 7) ^ 8'h5A);
  endfunction

  assign arr_rdata = mem[ix(arr_addr)];
  always @(posedge clk) begin
    if (fill_en) for (int k = 0; k < 256; k++) mem[k] <= pat(k);
    if (arr_we) mem[ix(arr_addr)] <= arr_wdata;
    if (arr_erase) for (int k = 0; k < 32; k++) mem[{arr_addr[18:16], 5'(k)}] <= 8'hFF;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(input logic [18:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask
  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
  endtask
  task automatic unl();
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
  endtask
  task automatic prog(input logic [18:0] a, input logic [7:0] d);
    unl(); wr(19'h05555, 8'hA0); wr(a, d);
  endtask
  task automatic erase(input logic [18:0] a);
    unl(); wr(19'h05555, 8'h80); unl(); wr(a, 8'h30);
  endtask
  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v, v2, d;
    logic [18:0] a;
    int n;
    void'($urandom(32'd4711));
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    boot_lock_n = 1'b1; wprot_n = 1'b1; fill_en = 1'b1;
    for (int k = 0; k < 256; k++) expm[k] = pat(k);
    repeat (3) @(negedge clk);
    fill_en = 1'b0;
    chk(busy == 1'b0 && rdata == 8'h00, "R10 reset state", {busy, rdata}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R10 idle after reset", busy, 0);

    // R11 plain read
    rd(19'h10003, v);
    chk(v == expm[ix(19'h10003)], "R11 idle read", v, expm[ix(19'h10003)]);
    rd(19'h00000, v);
    chk(v == expm[0], "R10 not in id mode", v, expm[0]);

    // R1 program duration and result
    a = 19'h10004; d = expm[ix(a)] & 8'h3C;
    prog(a, d); wait_idle(n);
    chk(n == PROG_C, "R1 program busy length", n, PROG_C);
    expm[ix(a)] = d;
    rd(a, v); chk(v == d, "R1 programmed data", v, d);

    // R3/R4 program status
    a = 19'h20005; d = expm[ix(a)] & 8'h70;
    prog(a, d);
    rd(a, v);  chk(v == {~d[7], 7'b0}, "R3 program status", v, {~d[7], 7'b0});
    rd(a, v2); chk(v2 == {~d[7], 1'b1, 6'b0}, "R4 toggle on second read", v2, {~d[7], 1'b1, 6'b0});
    rd(19'h0, v); chk(v == {~d[7], 7'b0}, "R4 toggle on third read", v, {~d[7], 7'b0});
    wait_idle(n); expm[ix(a)] = d;
    rd(a, v); chk(v == d, "R1 data after status reads", v, d);

    // R2 erase
    erase(19'h30007); wait_idle(n);
    chk(n == ERASE_C, "R2 erase busy length", n, ERASE_C);
    for (int k = 0; k < 32; k++) expm[{3'd3, 5'(k)}] = 8'hFF;
    rd(19'h30000, v); chk(v == 8'hFF, "R2 sector start erased", v, 8'hFF);
    rd(19'h3001F, v); chk(v == 8'hFF, "R2 sector end erased", v, 8'hFF);
    rd(19'h40002, v); chk(v == expm[ix(19'h40002)], "R2 other sector kept", v, expm[ix(19'h40002)]);

    // R3 erase status
    erase(19'h50011);
    rd(19'h50011, v);  chk(v == 8'h00, "R3 erase status", v, 8'h00);
    rd(19'h50011, v2); chk(v2 == 8'h40, "R4 erase toggle", v2, 8'h40);
    wait_idle(n);
    for (int k = 0; k < 32; k++) expm[{3'd5, 5'(k)}] = 8'hFF;
    rd(19'h50003, v); chk(v == 8'hFF, "R2 second erase", v, 8'hFF);

    // R6 protection
    wprot_n = 1'b0;
    prog(19'h20001, 8'h00); wait_idle(n);
    chk(n == PROT_C, "R6 protected program length", n, PROT_C);
    rd(19'h20001, v); chk(v == expm[ix(19'h20001)], "R6 protected program no change", v, expm[ix(19'h20001)]);
    wprot_n = 1'b1; boot_lock_n = 1'b0;
    erase(19'h70000); wait_idle(n);
    chk(n == PROT_C, "R6 protected erase length", n, PROT_C);
    rd(19'h70004, v); chk(v == expm[ix(19'h70004)], "R6 boot sector kept", v, expm[ix(19'h70004)]);
    a = 19'h60002; d = expm[ix(a)] & 8'h0F;
    prog(a, d); wait_idle(n); expm[ix(a)] = d;
    chk(n == PROG_C, "R6 non-boot sector open", n, PROG_C);

    // R7/R8 identification
    unl(); wr(19'h05555, 8'h90);
    rd(19'h00000, v); chk(v == 8'hDA, "R7 maker code", v, 8'hDA);
    rd(19'h00001, v); chk(v == 8'h54, "R7 part code", v, 8'h54);
    rd(19'h7FFF2, v); chk(v == 8'h04, "R7 pin status boot low", v, 8'h04);
    boot_lock_n = 1'b1; wprot_n = 1'b0;
    rd(19'h7FFF2, v); chk(v == 8'h08, "R7 pin status wp low", v, 8'h08);
    wprot_n = 1'b1;
    wr(19'h00123, 8'hF0);
    rd(19'h00000, v); chk(v == expm[0], "R8 single-write exit", v, expm[0]);
    unl(); wr(19'h05555, 8'h90);
    rd(19'h00001, v); chk(v == 8'h54, "R7 re-entry", v, 8'h54);
    unl(); wr(19'h05555, 8'hF0);
    rd(19'h00001, v); chk(v == expm[1], "R8 chained exit", v, expm[1]);

    // R9 broken chains
    a = 19'h10009;
    unl(); wr(19'h05555, 8'h12); wr(a, 8'h00);
    chk(busy == 1'b0, "R9 bad command byte", busy, 0);
    wr(19'h05555, 8'hAA); wr(19'h01234, 8'h55); wr(19'h05555, 8'hA0); wr(a, 8'h00);
    chk(busy == 1'b0, "R9 bad unlock address", busy, 0);
    unl(); wr(19'h05555, 8'h80); wr(19'h05555, 8'h77); unl(); wr(19'h30000, 8'h30);
    chk(busy == 1'b0, "R9 broken erase chain", busy, 0);
    rd(a, v); chk(v == expm[ix(a)], "R9 array unchanged", v, expm[ix(a)]);

    // random programs and erases
    for (int it = 0; it < 40; it++) begin
      a = {3'($urandom_range(0, 6)), 11'b0, 5'($urandom)};
      if (it % 10 == 9) begin
        erase(a); wait_idle(n);
        for (int k = 0; k < 32; k++) expm[{a[18:16], 5'(k)}] = 8'hFF;
        chk(n == ERASE_C, "R2 random erase length", n, ERASE_C);
      end else begin
        d = expm[ix(a)] & 8'($urandom);
        prog(a, d); wait_idle(n); expm[ix(a)] = d;
        chk(n == PROG_C, "R1 random program length", n, PROG_C);
      end
      rd(a, v); chk(v == expm[ix(a)], "R1 random readback", v, expm[ix(a)]);
    end

    // R5 one over zero
    a = 19'h40008;
    prog(a, 8'h00); wait_idle(n); expm[ix(a)] = 8'h00;
    prog(a, 8'h01);
    rd(a, v);  chk(v == 8'hA0, "R5 timeout status", v, 8'hA0);
    rd(a, v2); chk(v2 == 8'hE0, "R5 timeout toggles", v2, 8'hE0);
    repeat (200) @(negedge clk);
    chk(busy == 1'b1, "R5 stays busy", busy, 1);
    prog(19'h40009, 8'h00);
    rd(19'h40009, v); chk(v[5] == 1'b1, "R5 writes ignored", v, 8'hA0);
    do_reset();
    chk(busy == 1'b0, "R5 reset clears", busy, 0);
    rd(a, v); chk(v == 8'h00, "R5 no array write", v, 8'h00);
    rd(19'h40009, v); chk(v == expm[ix(19'h40009)], "R5 ignored program", v, expm[ix(19'h40009)]);

    summary();
    $finish;
  end
endmodule